// File: doc/BRIEF.md
# Staged Reset Release Sequencer with Strap Capture

This block controls how a chip leaves power-on reset. An active-low external power-on reset first goes through a two-flop synchroniser and a minimum-width qualifier in the input-clock domain. A qualified reset holds every reset output asserted. When the external reset is released, an internal power-on reset is held for a fixed number of input-clock cycles and then released. At that same edge, the fourteen configuration strap pins are captured into a registered strap word.

The reference-clock domain takes over from there. It receives the internal power-on reset and a PLL lock indication, each through its own synchroniser. It ignores lock until the internal power-on reset is released. Once lock is seen, a single counter releases the hard reset first and the soft reset a few cycles later. A completion flag rises with the soft reset.

A configuration word is also kept. It can be written after internal release through one of two write strobes, and only the strobe selected by a strap bit is accepted. If nothing is written, a slave-mode device uses a built-in default word and a master-mode device reads zero.

Top module: `rst_release_seq`

## Requirements
- R1: A low pulse on `ext_por_n` shorter than 16 `clk_in` cycles (`MIN_W`) leaves every output unchanged. A low level held for 40 or more cycles is a qualified reset.
- R2: `ipor_n` rises between 1024 and 1029 `clk_in` cycles after `ext_por_n` rises. This window is `IPOR_DLY` plus the synchroniser and qualifier latency.
- R3: While `ipor_n` is low, `hrst_n`, `srst_n` and `seq_done` stay low, and a `pll_lock` that is already high has no effect.
- R4: `hrst_n` rises between 512 and 517 `clk_ref` cycles after `pll_lock` rises. This window is `HRST_DLY` plus the synchroniser latency.
- R5: `srst_n` rises exactly 3 `clk_ref` cycles after `hrst_n` (`SRST_DLY - HRST_DLY`), `seq_done` rises together with it, and `srst_n` is never high while `hrst_n` is low.
- R6: `strap_word` holds the `straps` value from the `clk_in` edge where `ipor_n` rises, and later strap changes do not alter it. The bit fields are: [13] write path (1 = system-bus strobe, 0 = direct-port strobe), [12] slave mode (1 = slave), [11] sync select, [10] bus-width select, [9:6] chip ID, [5:3] boot mode, [2] watchdog enable, [1:0] clock mode.
- R7: A write loads `cfg_wr_data` into `cfg_word` within 2 `clk_in` cycles. It is accepted only from the strobe that strap bit 13 selects (`sbus_wr` or `dsp_wr`) and only while `ipor_n` is high. Any other strobe leaves `cfg_word` unchanged.
- R8: If no write has been accepted, `cfg_word` reads `DEFAULT_CFG` (32'hC0DE0001) when strap bit 12 is 1 and reads zero when it is 0.
- R9: Within 40 `clk_in` cycles, a qualified reset drives `ipor_n`, `hrst_n`, `srst_n`, `seq_done`, `strap_word` and `cfg_word` low and forgets any earlier write. The whole sequence then runs again.
- R10: Once lock has been seen, a later drop of `pll_lock` does not stop or undo the release of `hrst_n` and `srst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; runs the filter, internal reset delay, strap capture and config word |
| clk_ref | input | 1 | Reference clock; runs the hard and soft reset release |
| ext_por_n | input | 1 | External power-on reset, active low, asynchronous |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| straps | input | 14 | Configuration strap pins |
| dsp_wr | input | 1 | Config write strobe, direct-port path (`clk_in`) |
| sbus_wr | input | 1 | Config write strobe, system-bus path (`clk_in`) |
| cfg_wr_data | input | 32 | Config data carried by either strobe |
| ipor_n | output | 1 | Internal power-on reset, active low (`clk_in`) |
| hrst_n | output | 1 | Hard reset, active low (`clk_ref`) |
| srst_n | output | 1 | Soft reset, active low (`clk_ref`) |
| seq_done | output | 1 | High once the soft reset is released (`clk_ref`) |
| strap_word | output | 14 | Captured strap bundle |
| cfg_word | output | 32 | Selected configuration word |

## Verification
The embedded properties check the following on every cycle:
- The hard and soft reset stay ordered.
- The hard reset never releases before lock is latched.
- The strap word stays frozen while the internal reset is released.
- Writes happen only after release.
- A qualified reset comes only from a sustained low input.

Only the bench scenarios can show the rest:
- The absolute delays in input-clock and reference-clock cycles.
- That a short glitch is ignored.
- That writes on the unselected strobe are dropped.
- The default-word fallback in each mode.
- That a re-asserted reset clears everything and the sequence restarts with new straps.

// File: rtl/rst_seq_pkg.sv
// Shared constants for the staged reset release sequencer.
// Assumes a 14-bit strap bundle with the write-path and slave-mode
// selects in the two top bits; the remaining fields pass through.
package rst_seq_pkg;
    localparam int STRAP_W   = 14;
    localparam int IDX_PATH  = 13;
    localparam int IDX_SLAVE = 12;

    typedef enum logic {
        PATH_DIRECT = 1'b0,
        PATH_SYSBUS = 1'b1
    } cfg_path_e;
endpackage

// File: rtl/por_sync2.sv
// Two-flop synchroniser for W independent single-bit level signals.
// Assumes each bit is a slow level (reset or lock) so bits may
// resolve in different cycles; carries no reset on purpose.
module por_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the destination clock.
    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/por_filter.sv
// Minimum-width qualifier for the synchronised external reset.
// qual_rst_n falls only after MIN_W consecutive low samples and rises
// on the first high sample. The all-zero state is "reset held".
module por_filter #(
    parameter int MIN_W = 16
) (
    input  logic clk,
    input  logic sync_n,
    output logic qual_rst_n
);
    localparam int CW = (MIN_W > 2) ? $clog2(MIN_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

    logic [CW-1:0] lo_cnt;

    // Count low samples; a high sample clears the count and releases.
    always_ff @(posedge clk) begin
        if (sync_n) begin
            lo_cnt     <= '0;
            qual_rst_n <= 1'b1;
        end else if (lo_cnt == LAST) begin
            qual_rst_n <= 1'b0;
        end else begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    AST_QUAL_NEEDS_LOW: assert property (@(posedge clk) disable iff (sync_n)
        $fell(qual_rst_n) |-> !$past(sync_n)) else $error("qualified without low input"); // R1
endmodule

// File: rtl/ipor_stage.sv
// Internal power-on reset delay and strap capture (input clock).
// Uses the qualified reset as its synchronous active-low reset; after
// DLY cycles of release it raises ipor_n and captures the straps.
module ipor_stage #(
    parameter int DLY = 1024,
    parameter int SW  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] straps,
    output logic          ipor_n,
    output logic [SW-1:0] strap_q
);
    localparam int CW = (DLY > 2) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] dcnt;

    // Delay the release, then latch the strap bundle on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt    <= '0;
            ipor_n  <= 1'b0;
            strap_q <= '0;
        end else if (!ipor_n) begin
            if (dcnt == LAST) begin
                ipor_n  <= 1'b1;
                strap_q <= straps;
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ipor_n && $past(ipor_n)) |-> $stable(strap_q)) else $error("strap word moved"); // R6
    AST_IPOR_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ipor_n) |-> $past(rst_n)) else $error("early internal release"); // R2
endmodule

// File: rtl/cfg_select.sv
// Configuration word holder. Accepts a write only after internal
// release and only from the strobe picked by the path strap; until a
// write lands it shows the default (slave) or zero (master).
module cfg_select
    import rst_seq_pkg::*;
#(
    parameter int              CW          = 32,
    parameter logic [CW-1:0]   DEFAULT_CFG = 32'hC0DE_0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ipor_n,
    input  cfg_path_e     path_sel,
    input  logic          slave_sel,
    input  logic          dsp_wr,
    input  logic          sbus_wr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cfg_word
);
    logic written;
    logic wr_ok;

    // Select the strobe of the strapped path, gated by release.
    always_comb begin
        wr_ok = ipor_n && ((path_sel == PATH_SYSBUS) ? sbus_wr : dsp_wr);
    end

    // Hold the written word, or track the mode-dependent fallback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written  <= 1'b0;
            cfg_word <= '0;
        end else if (wr_ok) begin
            written  <= 1'b1;
            cfg_word <= wr_data;
        end else if (!written) begin
            cfg_word <= slave_sel ? DEFAULT_CFG : '0;
        end
    end

    AST_WRITE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(written) |-> $past(ipor_n)) else $error("write before release"); // R7
    AST_WRITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        written |=> written) else $error("written flag lost"); // R7
endmodule

// File: rtl/ref_release.sv
// Hard/soft reset release in the reference-clock domain. Its
// synchronous active-low reset is the synchronised internal reset.
// Lock is latched once; one counter then releases hard, then soft.
module ref_release #(
    parameter int HRST_DLY = 512,
    parameter int SRST_DLY = 515
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    output logic hrst_n,
    output logic srst_n,
    output logic done
);
    localparam int RW = $clog2(SRST_DLY + 1);
    localparam logic [RW-1:0] H_LAST = RW'(HRST_DLY - 1);
    localparam logic [RW-1:0] S_LAST = RW'(SRST_DLY - 1);

    logic          locked;
    logic [RW-1:0] rcnt;

    // Latch lock, then count to the hard and soft release points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            rcnt   <= '0;
            hrst_n <= 1'b0;
            srst_n <= 1'b0;
            done   <= 1'b0;
        end else if (!locked) begin
            locked <= lock_s;
        end else if (!srst_n) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == H_LAST) hrst_n <= 1'b1;
            if (rcnt == S_LAST) begin
                srst_n <= 1'b1;
                done   <= 1'b1;
            end
        end
    end

    AST_HARD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrst_n) |-> locked) else $error("hard release without lock"); // R4
    AST_SOFT_AFTER_HARD: assert property (@(posedge clk) disable iff (!rst_n)
        !hrst_n |-> !srst_n) else $error("soft released before hard"); // R5
    AST_SOFT_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_n) |-> (hrst_n && $past(hrst_n))) else $error("soft rise order"); // R5
    AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        hrst_n |=> hrst_n) else $error("hard reset dropped without reset"); // R10
endmodule

// File: rtl/rst_release_seq.sv
// Top of the staged reset release sequencer. Assumes clk_in and
// clk_ref are both running during reset; ext_por_n and pll_lock are
// asynchronous. Only ipor_n and lock cross into the reference domain.
module rst_release_seq
    import rst_seq_pkg::*;
#(
    parameter int            MIN_W       = 16,
    parameter int            IPOR_DLY    = 1024,
    parameter int            HRST_DLY    = 512,
    parameter int            SRST_DLY    = 515,
    parameter int            CFG_W       = 32,
    parameter logic [31:0]   DEFAULT_CFG = 32'hC0DE_0001
) (
    input  logic                clk_in,
    input  logic                clk_ref,
    input  logic                ext_por_n,
    input  logic                pll_lock,
    input  logic [STRAP_W-1:0]  straps,
    input  logic                dsp_wr,
    input  logic                sbus_wr,
    input  logic [CFG_W-1:0]    cfg_wr_data,
    output logic                ipor_n,
    output logic                hrst_n,
    output logic                srst_n,
    output logic                seq_done,
    output logic [STRAP_W-1:0]  strap_word,
    output logic [CFG_W-1:0]    cfg_word
);
    logic       ext_s;
    logic       qual_rst_n;
    logic [1:0] ref_s;
    cfg_path_e  path_sel;

    por_sync2 #(.W(1)) u_sync_in (
        .clk (clk_in),
        .d   (ext_por_n),
        .q   (ext_s)
    );

    por_filter #(.MIN_W(MIN_W)) u_filter (
        .clk        (clk_in),
        .sync_n     (ext_s),
        .qual_rst_n (qual_rst_n)
    );

    ipor_stage #(.DLY(IPOR_DLY), .SW(STRAP_W)) u_ipor (
        .clk     (clk_in),
        .rst_n   (qual_rst_n),
        .straps  (straps),
        .ipor_n  (ipor_n),
        .strap_q (strap_word)
    );

    // Decode the write-path strap into the path type.
    always_comb begin
        path_sel = strap_word[IDX_PATH] ? PATH_SYSBUS : PATH_DIRECT;
    end

    cfg_select #(.CW(CFG_W), .DEFAULT_CFG(CFG_W'(DEFAULT_CFG))) u_cfg (
        .clk       (clk_in),
        .rst_n     (qual_rst_n),
        .ipor_n    (ipor_n),
        .path_sel  (path_sel),
        .slave_sel (strap_word[IDX_SLAVE]),
        .dsp_wr    (dsp_wr),
        .sbus_wr   (sbus_wr),
        .wr_data   (cfg_wr_data),
        .cfg_word  (cfg_word)
    );

    por_sync2 #(.W(2)) u_sync_ref (
        .clk (clk_ref),
        .d   ({ipor_n, pll_lock}),
        .q   (ref_s)
    );

    ref_release #(.HRST_DLY(HRST_DLY), .SRST_DLY(SRST_DLY)) u_ref (
        .clk    (clk_ref),
        .rst_n  (ref_s[1]),
        .lock_s (ref_s[0]),
        .hrst_n (hrst_n),
        .srst_n (srst_n),
        .done   (seq_done)
    );
endmodule

// File: tb/rst_release_seq_test.sv
module rst_release_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 8;
    localparam logic [31:0] DEF = 32'hC0DE_0001;
    localparam logic [13:0] S1  = 14'h36AE;  // sysbus path, slave
    localparam logic [13:0] S2  = 14'h0A53;  // direct path, master

    logic clk_in = 1'b0, clk_ref = 1'b0;
    logic ext_por_n = 1'b0, pll_lock = 1'b0, dsp_wr = 1'b0, sbus_wr = 1'b0;
    logic [13:0] straps = '0;
    logic [31:0] cfg_wr_data = '0;
    logic ipor_n, hrst_n, srst_n, seq_done;
    logic [13:0] strap_word;
    logic [31:0] cfg_word;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;
    always #(REF_PERIOD/2) clk_ref = ~clk_ref;

    rst_release_seq uut (
        .clk_in(clk_in), .clk_ref(clk_ref), .ext_por_n(ext_por_n),
        .pll_lock(pll_lock), .straps(straps), .dsp_wr(dsp_wr),
        .sbus_wr(sbus_wr), .cfg_wr_data(cfg_wr_data), .ipor_n(ipor_n),
        .hrst_n(hrst_n), .srst_n(srst_n), .seq_done(seq_done),
        .strap_word(strap_word), .cfg_word(cfg_word)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_in(input int n);
        repeat (n) @(negedge clk_in);
    endtask

    task automatic release_and_measure(output int cyc);
        @(negedge clk_in);
        ext_por_n = 1'b1;
        cyc = 0;
        while (!ipor_n && cyc < 3000) begin
            @(negedge clk_in);
            cyc++;
        end
    endtask

    task automatic strobe(input bit use_sbus, input logic [31:0] data);
        @(negedge clk_in);
        cfg_wr_data = data;
        if (use_sbus) sbus_wr = 1'b1; else dsp_wr = 1'b1;
        @(negedge clk_in);
        sbus_wr = 1'b0;
        dsp_wr = 1'b0;
        wait_in(3);
    endtask

    task automatic t_reset_state();
        wait_in(40);
        chk(ipor_n == 0, "R3 ipor held", ipor_n, 0);
        chk({hrst_n, srst_n, seq_done} == 3'b000, "R3 ref outputs held", {hrst_n, srst_n, seq_done}, 0);
        chk(cfg_word == 0, "R9 cfg in reset", cfg_word, 0);
    endtask

    task automatic t_boot_slave();
        int cyc;
        straps = S1;
        release_and_measure(cyc);
        chk(cyc >= 1024 && cyc <= 1029, "R2 ipor delay", cyc, 1027);
        @(negedge clk_in);
        straps = 14'h1555;
        wait_in(4);
        chk(strap_word == S1, "R6 strap capture", strap_word, S1);
        chk(cfg_word == DEF, "R8 slave default", cfg_word, DEF);
        repeat (20) @(negedge clk_ref);
        chk(hrst_n == 0 && seq_done == 0, "R3 waits for lock", hrst_n, 0);
    endtask

    task automatic t_lock();
        int cyc, gap;
        @(negedge clk_ref);
        pll_lock = 1'b1;
        cyc = 0;
        while (!hrst_n && cyc < 2000) begin
            @(negedge clk_ref);
            cyc++;
        end
        chk(cyc >= 512 && cyc <= 517, "R4 hard delay", cyc, 515);
        chk(srst_n == 0, "R5 soft still held", srst_n, 0);
        gap = 0;
        while (!srst_n && gap < 50) begin
            @(negedge clk_ref);
            gap++;
        end
        chk(gap == 3, "R5 soft gap", gap, 3);
        chk(seq_done == 1, "R5 done with soft", seq_done, 1);
        pll_lock = 1'b0;
        repeat (20) @(negedge clk_ref);
        chk({hrst_n, srst_n, seq_done} == 3'b111, "R10 lock drop ignored", {hrst_n, srst_n, seq_done}, 3'b111);
    endtask

    task automatic t_cfg_slave();
        strobe(1'b0, 32'hDEAD_BEEF);
        chk(cfg_word == DEF, "R7 wrong strobe ignored", cfg_word, DEF);
        strobe(1'b1, 32'h5A5A_0F0F);
        chk(cfg_word == 32'h5A5A_0F0F, "R7 sysbus write", cfg_word, 32'h5A5A_0F0F);
    endtask

    task automatic t_glitch();
        @(negedge clk_in);
        ext_por_n = 1'b0;
        wait_in(8);
        ext_por_n = 1'b1;
        wait_in(30);
        repeat (4) @(negedge clk_ref);
        chk({ipor_n, hrst_n, srst_n, seq_done} == 4'hF, "R1 glitch ignored", {ipor_n, hrst_n, srst_n, seq_done}, 4'hF);
        chk(cfg_word == 32'h5A5A_0F0F, "R1 cfg kept", cfg_word, 32'h5A5A_0F0F);
        chk(strap_word == S1, "R1 straps kept", strap_word, S1);
    endtask

    task automatic t_reassert_master();
        int cyc;
        @(negedge clk_in);
        ext_por_n = 1'b0;
        wait_in(40);
        chk({ipor_n, hrst_n, srst_n, seq_done} == 4'h0, "R9 outputs reasserted", {ipor_n, hrst_n, srst_n, seq_done}, 0);
        chk(strap_word == 0 && cfg_word == 0, "R9 words cleared", {strap_word, cfg_word}, 0);
        straps = S2;
        pll_lock = 1'b1;
        strobe(1'b0, 32'h1111_2222);
        chk(cfg_word == 0, "R7 write in reset ignored", cfg_word, 0);
        chk(hrst_n == 0, "R3 lock ignored in reset", hrst_n, 0);
        release_and_measure(cyc);
        chk(cyc >= 1024 && cyc <= 1029, "R2 ipor delay rerun", cyc, 1027);
        repeat (2) @(negedge clk_ref);
        chk(hrst_n == 0, "R3 no early hard release", hrst_n, 0);
        wait_in(3);
        chk(strap_word == S2, "R6 rerun straps", strap_word, S2);
        chk(cfg_word == 0, "R8 master no default", cfg_word, 0);
        repeat (600) @(negedge clk_ref);
        chk({hrst_n, srst_n, seq_done} == 3'b111, "R9 sequence restarted", {hrst_n, srst_n, seq_done}, 3'b111);
        strobe(1'b1, 32'h3333_4444);
        chk(cfg_word == 0, "R7 sysbus ignored on direct path", cfg_word, 0);
        strobe(1'b0, 32'h1234_5678);
        chk(cfg_word == 32'h1234_5678, "R7 direct write", cfg_word, 32'h1234_5678);
    endtask

    initial begin
        t_reset_state();
        t_boot_slave();
        t_lock();
        t_cfg_slave();
        t_glitch();
        t_reassert_master();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_in);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule